// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM refreshed on behalf of a memory controller. A free-running interval timer marks each refresh slot. When a slot comes due and the read/write arbiter has released the bus, the sequencer claims the bus. It closes every bank with a precharge-all and waits out the row-precharge time. It then issues AUTO REFRESH and holds the bus for the refresh cycle time. Slots that fall while the arbiter keeps the bus are counted up to a limit. Once the bus is released, they are paid back with back-to-back refreshes.

On a power-down request the sequencer precharges all banks and enters self refresh: the refresh command goes out with CKE driven low. It acknowledges once CKE is low and keeps the device asleep for at least the minimum dwell. When the request is withdrawn it raises CKE and sends only NOPs for the exit delay. It then issues one AUTO REFRESH and restarts the interval timer from zero. The command bus carries no address, because refresh commands take none. All timing values are parameters in clock cycles. Values below two are raised to two.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset is held and after it is released, the command output is NOP, CKE is high, busy is low and the sleep acknowledge is low. The command encoding is 2'b00 NOP, 2'b01 precharge-all, 2'b10 AUTO REFRESH and 2'b11 self-refresh entry.
- R2: With the bus granted continuously, successive refresh precharges are exactly T_REFI cycles apart. The interval timer keeps running while refreshes are served.
- R3: AUTO REFRESH follows the precharge-all that opens the sequence exactly T_RP cycles later.
- R4: Successive AUTO REFRESH commands are exactly T_RC cycles apart. Busy rises with the precharge and falls T_RC cycles after the last refresh, so a sequence of n refreshes is busy for T_RP + n*T_RC cycles.
- R5: While the grant is low and the sequencer is idle, only NOP is issued and busy stays low. A due refresh stays pending. The precharge appears one cycle after the grant returns.
- R6: The count of unserved intervals saturates at MAX_MISSED. A release after k missed intervals yields exactly min(k, MAX_MISSED) refreshes behind a single precharge-all.
- R7: A sleep request is honoured only when no refresh is pending. A pending refresh is precharged and refreshed first, and self-refresh entry comes after it.
- R8: Self-refresh entry is a precharge-all followed T_RP cycles later by command 2'b11 with CKE low in that same cycle. The acknowledge is high from the next cycle for as long as CKE stays low.
- R9: Once low, CKE stays low for at least T_RAS cycles and for as long as the sleep request stays high. Only NOP is issued meanwhile. With the request already low, CKE rises exactly T_RAS cycles after entry. Otherwise it rises one cycle after the request falls.
- R10: After CKE rises, only NOP is issued for T_XSR cycles. AUTO REFRESH follows exactly T_XSR cycles after the rise.
- R11: Exit restarts the interval: the next refresh precharge comes exactly T_REFI + 2 cycles after CKE rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busGrant | input | 1 | Arbiter has released the bus to the sequencer |
| sleepReq | input | 1 | Power-down request; level held for the whole sleep |
| cmdOut | output | 2 | Command to the SDRAM (encoding in R1) |
| cke | output | 1 | Clock enable to the SDRAM |
| seqBusy | output | 1 | Sequencer owns the command bus |
| sleepAck | output | 1 | Device is in self refresh with CKE low |

## Verification
Two events can land together. One is a sleep request arriving while a refresh interval has just expired under a held bus. The other is the interval tick falling in the same cycle as a refresh that is draining the missed count. The bench provokes the first by withholding the grant across a tick, then raising the sleep request and the grant together. It is judged by the order of the commands that follow: precharge and refresh must come before the self-refresh entry. Missed-interval sweeps from one to five intervals are judged on burst length, on spacing, and on the phase of the next precharge, which must not slip.

// File: rtl/srseq_pkg.sv
package srseq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PREA = 2'b01,
    CMD_AREF = 2'b10,
    CMD_SREF = 2'b11
  } srseq_cmd_e;

  typedef enum logic [2:0] {
    WS_NONE,
    WS_RP,
    WS_RC,
    WS_RAS,
    WS_XSR
  } srseq_wsel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_AREF,
    ST_WAIT,
    ST_SRIN,
    ST_DWELL,
    ST_SREXIT
  } srseq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        arefIssued;
    logic        timerHold;
    srseq_wsel_e waitSel;
  } srseq_strb_t;

  function automatic int clampTwo(input int v);
    return (v < 2) ? 2 : v;
  endfunction

endpackage

// File: rtl/srseq_timers.sv
module srseq_timers
  import srseq_pkg::*;
#(
  parameter int T_REFI     = 390,
  parameter int T_RP       = 3,
  parameter int T_RC       = 4,
  parameter int T_RAS      = 3,
  parameter int T_XSR      = 4,
  parameter int MAX_MISSED = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  srseq_strb_t strb,
  output logic        refPending,
  output logic        waitLast
);

  localparam int RP_C  = clampTwo(T_RP);
  localparam int RC_C  = clampTwo(T_RC);
  localparam int RAS_C = clampTwo(T_RAS);
  localparam int XSR_C = clampTwo(T_XSR);
  localparam int REFI_C = clampTwo(T_REFI);
  localparam int MAXM_C = (MAX_MISSED < 1) ? 1 : MAX_MISSED;
  localparam int TW = $clog2(REFI_C + RP_C + RC_C + RAS_C + XSR_C + 4);
  localparam int MW = $clog2(MAXM_C + 1);

  logic [TW-1:0] intervalCnt;
  logic [MW-1:0] missedCnt;
  logic [TW-1:0] waitCnt;
  logic          tick;

  // interval timer: one tick per refresh slot, held at zero in self refresh
  assign tick = !strb.timerHold && (intervalCnt == TW'(REFI_C - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (strb.timerHold || tick) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  // missed-slot counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      missedCnt <= '0;
    end else begin
      case ({tick, strb.arefIssued})
        2'b10: if (missedCnt != MW'(MAXM_C)) missedCnt <= missedCnt + 1'b1;
        2'b01: if (missedCnt != '0) missedCnt <= missedCnt - 1'b1;
        2'b11: if (missedCnt == '0) missedCnt <= MW'(1);
        default: missedCnt <= missedCnt;
      endcase
    end
  end

  assign refPending = (missedCnt != '0);

  // shared wait counter for tRP, tRC, tRAS and tXSR
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else begin
      case (strb.waitSel)
        WS_RP:   waitCnt <= TW'(RP_C - 1);
        WS_RC:   waitCnt <= TW'(RC_C - 1);
        WS_RAS:  waitCnt <= TW'(RAS_C - 1);
        WS_XSR:  waitCnt <= TW'(XSR_C - 1);
        default: if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      endcase
    end
  end

  assign waitLast = (waitCnt <= TW'(1));

  p_missed_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (missedCnt == MW'(MAXM_C) && tick && !strb.arefIssued) |=> (missedCnt == MW'(MAXM_C)));

  p_missed_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    missedCnt <= MW'(MAXM_C));

  p_hold_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.timerHold |=> (intervalCnt == '0));

endmodule

// File: rtl/srseq_ctrl.sv
module srseq_ctrl
  import srseq_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RC  = 4,
  parameter int T_RAS = 3,
  parameter int T_XSR = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busGrant,
  input  logic        sleepReq,
  input  logic        refPending,
  input  logic        waitLast,
  output srseq_strb_t strb,
  output srseq_cmd_e  cmd,
  output logic        cke,
  output logic        seqBusy,
  output logic        sleepAck
);

  localparam int RP_C  = clampTwo(T_RP);
  localparam int RC_C  = clampTwo(T_RC);
  localparam int RAS_C = clampTwo(T_RAS);
  localparam int XSR_C = clampTwo(T_XSR);
  localparam int CW = $clog2(RP_C + RC_C + RAS_C + XSR_C + 8) + 1;

  srseq_state_e st, nextSt;
  srseq_state_e waitTgt, nextTgt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      waitTgt <= ST_IDLE;
    end else begin
      st      <= nextSt;
      waitTgt <= nextTgt;
    end
  end

  always_comb begin
    nextSt  = st;
    nextTgt = waitTgt;
    strb    = '{arefIssued: 1'b0, timerHold: 1'b0, waitSel: WS_NONE};
    case (st)
      ST_IDLE: begin
        if (busGrant && refPending) begin
          nextSt  = ST_PRE;
          nextTgt = ST_AREF;
        end else if (busGrant && sleepReq) begin
          nextSt  = ST_PRE;
          nextTgt = ST_SRIN;
        end
      end
      ST_PRE: begin
        strb.waitSel = WS_RP;
        nextSt       = ST_WAIT;
      end
      ST_AREF: begin
        strb.arefIssued = 1'b1;
        strb.waitSel    = WS_RC;
        nextSt          = ST_WAIT;
        nextTgt         = ST_IDLE;
      end
      ST_WAIT: begin
        if (waitLast) begin
          if (waitTgt == ST_IDLE) nextSt = refPending ? ST_AREF : ST_IDLE;
          else                    nextSt = waitTgt;
        end
      end
      ST_SRIN: begin
        strb.timerHold = 1'b1;
        strb.waitSel   = WS_RAS;
        nextSt         = ST_DWELL;
      end
      ST_DWELL: begin
        strb.timerHold = 1'b1;
        if (waitLast && !sleepReq) nextSt = ST_SREXIT;
      end
      ST_SREXIT: begin
        strb.timerHold = 1'b1;
        strb.waitSel   = WS_XSR;
        nextSt         = ST_WAIT;
        nextTgt        = ST_AREF;
      end
      default: nextSt = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st)
      ST_PRE:  cmd = CMD_PREA;
      ST_AREF: cmd = CMD_AREF;
      ST_SRIN: cmd = CMD_SREF;
      default: cmd = CMD_NOP;
    endcase
  end

  assign cke      = !(st == ST_SRIN || st == ST_DWELL);
  assign seqBusy  = (st != ST_IDLE);
  assign sleepAck = (st == ST_DWELL);

  // elapsed-cycle counters for the timing checks
  logic [CW-1:0] sincePre, sinceAref, ckeLowCnt, ckeHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sincePre   <= '1;
      sinceAref  <= '1;
      ckeLowCnt  <= '0;
      ckeHighCnt <= '1;
    end else begin
      if (cmd == CMD_PREA)      sincePre <= CW'(1);
      else if (sincePre != '1)  sincePre <= sincePre + 1'b1;
      if (cmd == CMD_AREF)      sinceAref <= CW'(1);
      else if (sinceAref != '1) sinceAref <= sinceAref + 1'b1;
      if (!cke) ckeLowCnt <= (ckeLowCnt != '1) ? ckeLowCnt + 1'b1 : ckeLowCnt;
      else      ckeLowCnt <= '0;
      if (cke)  ckeHighCnt <= (ckeHighCnt != '1) ? ckeHighCnt + 1'b1 : ckeHighCnt;
      else      ckeHighCnt <= '0;
    end
  end

  p_rp_before_aref_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_AREF) |-> (sincePre >= CW'(RP_C)));

  p_rc_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_AREF) |-> (sinceAref >= CW'(RC_C)));

  p_quiet_without_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!seqBusy && !busGrant) |=> (cmd == CMD_NOP && !seqBusy));

  p_entry_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> (cmd == CMD_SREF));

  p_ack_after_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepAck) |-> ($past(cmd) == CMD_SREF && !cke));

  p_min_dwell_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (ckeLowCnt >= CW'(RAS_C)));

  p_xsr_nops_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cke && cmd != CMD_NOP) |-> (ckeHighCnt >= CW'(XSR_C)));

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import srseq_pkg::*;
#(
  parameter int T_REFI     = 390,
  parameter int T_RP       = 3,
  parameter int T_RC       = 4,
  parameter int T_RAS      = 3,
  parameter int T_XSR      = 4,
  parameter int MAX_MISSED = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGrant,
  input  logic       sleepReq,
  output logic [1:0] cmdOut,
  output logic       cke,
  output logic       seqBusy,
  output logic       sleepAck
);

  srseq_strb_t strb;
  srseq_cmd_e  cmdInt;
  logic        refPending;
  logic        waitLast;

  srseq_ctrl #(
    .T_RP (T_RP),
    .T_RC (T_RC),
    .T_RAS(T_RAS),
    .T_XSR(T_XSR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busGrant  (busGrant),
    .sleepReq  (sleepReq),
    .refPending(refPending),
    .waitLast  (waitLast),
    .strb      (strb),
    .cmd       (cmdInt),
    .cke       (cke),
    .seqBusy   (seqBusy),
    .sleepAck  (sleepAck)
  );

  srseq_timers #(
    .T_REFI    (T_REFI),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .T_RAS     (T_RAS),
    .T_XSR     (T_XSR),
    .MAX_MISSED(MAX_MISSED)
  ) u_timers (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .refPending(refPending),
    .waitLast  (waitLast)
  );

  assign cmdOut = cmdInt;

endmodule

// File: tb/sdram_refresh_seq_test.sv
module sdram_refresh_seq_test;

  localparam int REFI = 40;
  localparam int RP   = 3;
  localparam int RC   = 5;
  localparam int RAS  = 6;
  localparam int XSR  = 4;
  localparam int MAXM = 3;

  localparam logic [1:0] C_NOP  = 2'b00;
  localparam logic [1:0] C_PREA = 2'b01;
  localparam logic [1:0] C_AREF = 2'b10;
  localparam logic [1:0] C_SREF = 2'b11;

  logic clk = 1'b0;
  logic rstN;
  logic busGrant;
  logic sleepReq;
  logic [1:0] cmdOut;
  logic cke, seqBusy, sleepAck;

  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_seq #(
    .T_REFI(REFI), .T_RP(RP), .T_RC(RC), .T_RAS(RAS), .T_XSR(XSR), .MAX_MISSED(MAXM)
  ) uut (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .sleepReq(sleepReq),
    .cmdOut(cmdOut), .cke(cke), .seqBusy(seqBusy), .sleepAck(sleepAck)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic waitCmd(input logic [1:0] c, output int t);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (cmdOut != c && guard < 1000);
    t = cyc;
  endtask

  task automatic waitNonNop(output logic [1:0] c, output int t);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (cmdOut == C_NOP && guard < 1000);
    c = cmdOut;
    t = cyc;
  endtask

  task automatic waitBusyLow(output int t);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (seqBusy && guard < 1000);
    t = cyc;
  endtask

  initial begin
    int p, a, b, q, rel, n, last, s0, s, x, r;
    logic [1:0] c;
    bit bad;
    rstN = 1'b0;
    busGrant = 1'b1;
    sleepReq = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmdOut == C_NOP && cke && !seqBusy && !sleepAck, "R1 in reset",
          {cmdOut, cke, seqBusy, sleepAck}, 5'b00100);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdOut == C_NOP && cke && !seqBusy && !sleepAck, "R1 after reset",
          {cmdOut, cke, seqBusy, sleepAck}, 5'b00100);

    // steady refresh: R2, R3, R4
    waitCmd(C_PREA, p);
    for (int i = 0; i < 3; i++) begin
      waitCmd(C_AREF, a);
      check(a - p == RP, "R3 prea->aref", a - p, RP);
      waitBusyLow(b);
      check(b - p == RP + RC, "R4 busy span", b - p, RP + RC);
      waitCmd(C_PREA, q);
      check(q - p == REFI, "R2 interval", q - p, REFI);
      p = q;
    end

    // missed-interval sweep: R5, R6, R4, R2
    for (int k = 1; k <= 5; k++) begin
      int expN;
      waitBusyLow(b);
      busGrant = 1'b0;
      bad = 1'b0;
      while (cyc < p + k * REFI + 10) begin
        @(negedge clk);
        if (cmdOut != C_NOP || seqBusy) bad = 1'b1;
      end
      check(!bad, "R5 quiet while not granted", bad, 0);
      rel = cyc;
      busGrant = 1'b1;
      waitCmd(C_PREA, q);
      check(q == rel + 1, "R5 prea after grant", q - rel, 1);
      n = 0;
      last = q;
      bad = 1'b0;
      do begin
        @(negedge clk);
        if (cmdOut == C_AREF) begin
          if (n == 0) check(cyc - q == RP, "R3 burst first aref", cyc - q, RP);
          else        check(cyc - last == RC, "R4 burst spacing", cyc - last, RC);
          n++;
          last = cyc;
        end
        if (cmdOut == C_PREA) bad = 1'b1;
      end while (seqBusy);
      expN = (k < MAXM) ? k : MAXM;
      check(n == expN, "R6 burst length", n, expN);
      check(!bad, "R6 single precharge", bad, 0);
      check(cyc - q == RP + n * RC, "R4 burst busy span", cyc - q, RP + n * RC);
      waitCmd(C_PREA, q);
      check(q == p + (k + 1) * REFI, "R2 phase kept", q - p, (k + 1) * REFI);
      p = q;
    end

    // sleep request coinciding with a pending refresh: R7, R8, R9, R10, R11
    waitBusyLow(b);
    busGrant = 1'b0;
    while (cyc < p + REFI + 5) @(negedge clk);
    sleepReq = 1'b1;
    busGrant = 1'b1;
    waitNonNop(c, a);
    check(c == C_PREA, "R7 first cmd", c, C_PREA);
    waitNonNop(c, a);
    check(c == C_AREF, "R7 refresh before sleep", c, C_AREF);
    waitNonNop(c, s0);
    check(c == C_PREA, "R8 entry precharge", c, C_PREA);
    waitNonNop(c, s);
    check(c == C_SREF && !cke, "R8 entry cmd with cke low", {c, cke}, {C_SREF, 1'b0});
    check(s - s0 == RP, "R8 entry after tRP", s - s0, RP);
    @(negedge clk);
    check(sleepAck && !cke, "R8 ack", {sleepAck, cke}, 2'b10);
    bad = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (cke || cmdOut != C_NOP || !sleepAck) bad = 1'b1;
    end
    check(!bad, "R9 held asleep while requested", bad, 0);
    sleepReq = 1'b0;
    rel = cyc;
    @(negedge clk);
    x = cyc;
    check(cke && x == rel + 1 && !sleepAck, "R9 exit after request drop", {cke, sleepAck}, 2'b10);
    bad = 1'b0;
    repeat (XSR - 1) begin
      @(negedge clk);
      if (cmdOut != C_NOP || !cke) bad = 1'b1;
    end
    check(!bad, "R10 nops during exit delay", bad, 0);
    @(negedge clk);
    check(cmdOut == C_AREF && cyc == x + XSR, "R10 refresh after exit", cmdOut, C_AREF);
    waitCmd(C_PREA, q);
    check(q == x + REFI + 2, "R11 interval restart", q - x, REFI + 2);
    p = q;

    // minimum dwell: request withdrawn at entry
    waitBusyLow(b);
    sleepReq = 1'b1;
    waitCmd(C_SREF, s);
    sleepReq = 1'b0;
    r = s;
    do begin
      @(negedge clk);
    end while (!cke && cyc < s + 100);
    r = cyc;
    check(r - s == RAS, "R9 minimum dwell", r - s, RAS);
    waitCmd(C_AREF, a);
    check(a - r == XSR, "R10 exit delay", a - r, XSR);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule